// File: doc/BRIEF.md
# Super-pixel readout sequencer

This block is the digital controller for one square tile of pixels, 16 by 16 by default. It keeps two configuration bits for each pixel. One is a mask bit that removes the pixel from every output. The other is a test-injection enable that gates a shared test strobe onto the pixel's injection line. Both bits are loaded through a two-wire serial port.

Pixel hit flags are latched inside the block and combined into three fast-OR lines. The line for each pixel is chosen so that a pixel and its row or column neighbours always drive different lines. The latched flags stay set until a clear request arrives while the block is idle.

A start request snapshots the set of pixels that are hit and unmasked. The block then walks that set in ascending address order. For each pixel it drives the select address of an external analog multiplexer and waits for the fixed latency of the external converter. It captures the converter code and offers `{address, code}` on a valid/ready output. A one-cycle done pulse closes each readout.

The output stream follows these back-pressure rules:
- A word is transferred on each rising edge at which `out_valid_o` and `out_ready_i` are both high.
- While `out_valid_o` is high and `out_ready_i` is low, the word is held unchanged and is neither dropped nor repeated.
- The next conversion may complete during a stall. Its code is then held back, with its select address frozen, until the output register frees.

Top module: `spx_readout_seq`

## Requirements
- R1: After reset these outputs are all zero: `out_valid_o`, `done_o`, `busy_o`, `fastor_o`, `inject_o` and `sel_addr_o`. Every mask bit and every injection-enable bit is also zero.
- R2: While `cfg_en_i` is high, one `cfg_bit_i` is taken on each rising edge. Pixels are sent from the highest address (255) down to 0. For each pixel its mask bit comes first and its injection-enable bit second. After 512 such bits, pixel p holds the pair sent for it.
- R3: Serial configuration bits offered while `busy_o` is high are ignored. After that readout ends, the masks and enables it had at its start are unchanged.
- R4: `fastor_o[k]` is high one edge after some pixel that is latched as hit and unmasked has line number k = (col + 2*row) mod 3, where the address is row*16 + col. A masked pixel drives no line. A hit pulse on `hit_i` latches on the next edge, so the line rises on the second edge after the pulse.
- R5: `inject_o[p]` is high for the one cycle after an edge at which `tp_strobe_i` was high, and only for pixels whose injection enable is set. It is zero at all other times.
- R6: A readout emits exactly one word for each pixel that was hit and unmasked when start was taken, in strictly ascending address order. Masked or non-hit pixels produce no word.
- R7: `sel_addr_o` stays stable while a conversion is pending. The code on `adc_code_i` is captured on the second rising edge after `sel_addr_o` takes the pixel's address. The converter must present that pixel's code from the first cycle after the change.
- R8: The output word is the 8-bit address in bits [11:4] and the 4-bit code in bits [3:0]. During a stall `out_valid_o` stays high and `out_data_o` holds its value.
- R9: `done_o` is high for exactly the one cycle after the edge that accepts the last word. When the snapshot is empty, no word is sent and `done_o` is high during the second cycle after start is taken. `busy_o` is low whenever `done_o` is high.
- R10: `clear_i` empties the latched hit flags only while `busy_o` is low. A clear during a readout has no effect.
- R11: `start_i` is ignored while `busy_o` is high. When idle, `busy_o` rises on the edge that takes `start_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 200 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en_i | input | 1 | Serial configuration shift enable |
| cfg_bit_i | input | 1 | Serial configuration data bit |
| hit_i | input | 256 | Pixel hit pulses, one bit per pixel |
| clear_i | input | 1 | Clear latched hit flags (honoured only when idle) |
| tp_strobe_i | input | 1 | Shared test-injection strobe |
| inject_o | output | 256 | Per-pixel injection pulses |
| fastor_o | output | 3 | Fast-OR lines |
| start_i | input | 1 | Readout request |
| busy_o | output | 1 | Readout in progress |
| done_o | output | 1 | One-cycle end-of-readout pulse |
| sel_addr_o | output | 8 | Analog multiplexer select address |
| adc_code_i | input | 4 | Converter code for the selected pixel |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Output word accepted |
| out_data_o | output | 12 | {pixel address, code} |

## Verification
The bench builds the block with its default parameters: a 16 by 16 tile, three fast-OR lines, a 4-bit code and a conversion latency of two. This reaches address 0 and address 255 as boundary pixels, a readout of all 256 pixels, and the full 512-bit configuration chain. The converter model in the bench is a single register whose output depends on the address. A capture one edge too early therefore returns the previous pixel's code. Three ready patterns are used: always ready, ready two cycles in three, and long stalls. Together with the busy-time configuration, start and clear requests, they exercise the overlap between a held word and the next conversion.

// File: rtl/spx_pkg.sv
package spx_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_CONV  = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_t;

  // Line number of a pixel given its linear address (row*cols + col).
  function automatic int line_of(input int pix, input int cols, input int nlines);
    return ((pix % cols) + 2 * (pix / cols)) % nlines;
  endfunction

endpackage

// File: rtl/spx_cfg_chain.sv
module spx_cfg_chain #(
  parameter int NPIX = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            bit_in,
  output logic [NPIX-1:0] mask_o,
  output logic [NPIX-1:0] tpen_o
);
  localparam int CHAIN = 2 * NPIX;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (shift_en) begin
      chain_q <= {chain_q[CHAIN-2:0], bit_in};
    end
  end

  // Pixel p: odd chain bit holds the mask, even bit the injection enable.
  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    assign mask_o[p] = chain_q[2*p+1];
    assign tpen_o[p] = chain_q[2*p];
  end

endmodule

// File: rtl/spx_hit_fastor.sv
module spx_hit_fastor #(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int NLINES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ROWS*COLS-1:0]    hit_i,
  input  logic                    clear,
  input  logic [ROWS*COLS-1:0]    mask,
  output logic [ROWS*COLS-1:0]    hit_q_o,
  output logic [NLINES-1:0]       fastor_o
);
  localparam int NPIX = ROWS * COLS;

  logic [NPIX-1:0] hit_q;
  logic [NPIX-1:0] live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= '0;
    end else if (clear) begin
      hit_q <= hit_i;
    end else begin
      hit_q <= hit_q | hit_i;
    end
  end

  assign live    = hit_q & ~mask;
  assign hit_q_o = hit_q;

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    logic [NPIX-1:0] member;
    for (genvar p = 0; p < NPIX; p++) begin : g_member
      assign member[p] = (spx_pkg::line_of(p, COLS, NLINES) == l);
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fastor_o[l] <= 1'b0;
      end else begin
        fastor_o[l] <= |(live & member);
      end
    end
  end

endmodule

// File: rtl/spx_first_set.sv
module spx_first_set #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  rest_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = IW'(i);
      end
    end
  end

  assign found_o = |vec_i;
  // Removing the lowest set bit leaves the pixels still to be visited.
  assign rest_o  = vec_i & (vec_i - N'(1));

endmodule

// File: rtl/spx_readout_seq.sv
module spx_readout_seq #(
  parameter int ROWS     = 16,
  parameter int COLS     = 16,
  parameter int NLINES   = 3,
  parameter int CODE_W   = 4,
  parameter int CONV_LAT = 2,
  localparam int NPIX    = ROWS * COLS,
  localparam int AW      = $clog2(NPIX),
  localparam int DW      = AW + CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en_i,
  input  logic              cfg_bit_i,
  input  logic [NPIX-1:0]   hit_i,
  input  logic              clear_i,
  input  logic              tp_strobe_i,
  output logic [NPIX-1:0]   inject_o,
  output logic [NLINES-1:0] fastor_o,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [AW-1:0]     sel_addr_o,
  input  logic [CODE_W-1:0] adc_code_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DW-1:0]     out_data_o
);
  import spx_pkg::*;

  localparam int CNT_W = $clog2(CONV_LAT + 1);

  seq_state_t       state_q;
  logic [NPIX-1:0]  mask_w;
  logic [NPIX-1:0]  tpen_w;
  logic [NPIX-1:0]  hit_q_w;
  logic [NPIX-1:0]  cand_w;
  logic [NPIX-1:0]  pend_q;
  logic [NPIX-1:0]  scan_vec;
  logic [NPIX-1:0]  rest_w;
  logic             found_w;
  logic [AW-1:0]    idx_w;
  logic [CNT_W-1:0] cnt_q;
  logic             last_q;
  logic             slot_free;
  logic             conv_ready;
  logic             capture_w;
  logic             in_conv_w;

  assign busy_o = (state_q != SEQ_IDLE);

  spx_cfg_chain #(.NPIX(NPIX)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en_i && !busy_o),
    .bit_in   (cfg_bit_i),
    .mask_o   (mask_w),
    .tpen_o   (tpen_w)
  );

  spx_hit_fastor #(.ROWS(ROWS), .COLS(COLS), .NLINES(NLINES)) u_hits (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit_i),
    .clear    (clear_i && !busy_o),
    .mask     (mask_w),
    .hit_q_o  (hit_q_w),
    .fastor_o (fastor_o)
  );

  assign cand_w   = hit_q_w & ~mask_w;
  assign scan_vec = (state_q == SEQ_IDLE) ? cand_w : pend_q;

  spx_first_set #(.N(NPIX), .IW(AW)) u_first (
    .vec_i   (scan_vec),
    .found_o (found_w),
    .idx_o   (idx_w),
    .rest_o  (rest_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inject_o <= '0;
    end else begin
      inject_o <= tp_strobe_i ? tpen_w : '0;
    end
  end

  assign slot_free  = !out_valid_o || out_ready_i;
  assign in_conv_w  = (state_q == SEQ_CONV);
  assign conv_ready = in_conv_w && (cnt_q == CNT_W'(CONV_LAT - 1));
  assign capture_w  = conv_ready && slot_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      pend_q     <= '0;
      sel_addr_o <= '0;
      cnt_q      <= '0;
      last_q     <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            if (found_w) begin
              sel_addr_o <= idx_w;
              pend_q     <= rest_w;
              last_q     <= (rest_w == '0);
              cnt_q      <= '0;
              state_q    <= SEQ_CONV;
            end else begin
              pend_q  <= '0;
              state_q <= SEQ_DRAIN;
            end
          end
        end
        SEQ_CONV: begin
          if (capture_w) begin
            if (last_q) begin
              state_q <= SEQ_DRAIN;
            end else begin
              sel_addr_o <= idx_w;
              pend_q     <= rest_w;
              last_q     <= (rest_w == '0);
              cnt_q      <= '0;
            end
          end else if (!conv_ready) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        SEQ_DRAIN: begin
          if (slot_free) begin
            done_o  <= 1'b1;
            state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (capture_w) begin
      out_valid_o <= 1'b1;
      out_data_o  <= {sel_addr_o, adc_code_i};
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/spx_readout_seq_chk.sv
module spx_readout_seq_chk #(
  parameter int NPIX = 256,
  parameter int AW   = 8,
  parameter int CW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [AW+CW-1:0] out_data_o,
  input logic [AW-1:0]   sel_addr_o,
  input logic [NPIX-1:0] mask_w,
  input logic [NPIX-1:0] tpen_w,
  input logic [NPIX-1:0] inject_o,
  input logic            in_conv_w,
  input logic            capture_w
);
  logic [AW-1:0] out_addr;
  logic [AW-1:0] prev_addr;
  logic          have_prev;

  assign out_addr = out_data_o[AW+CW-1:CW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr <= '0;
      have_prev <= 1'b0;
    end else if (!busy_o) begin
      have_prev <= 1'b0;
    end else if (out_valid_o && out_ready_i) begin
      prev_addr <= out_addr;
      have_prev <= 1'b1;
    end
  end

  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(mask_w) && $stable(tpen_w)));

  p_inject_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((inject_o & ~$past(tpen_w)) == '0));

  p_no_masked_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !mask_w[out_addr]);

  p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && have_prev) |-> (out_addr > prev_addr));

  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_conv_w && !capture_w) |=> $stable(sel_addr_o));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !out_valid_o));

  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

endmodule

bind spx_readout_seq spx_readout_seq_chk #(
  .NPIX (NPIX),
  .AW   (AW),
  .CW   (CODE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .sel_addr_o  (sel_addr_o),
  .mask_w      (mask_w),
  .tpen_w      (tpen_w),
  .inject_o    (inject_o),
  .in_conv_w   (in_conv_w),
  .capture_w   (capture_w)
);

// File: tb/spx_readout_seq_tb.sv
module spx_readout_seq_tb;
  localparam int N  = 256;
  localparam int AW = 8;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_en_i = 1'b0, cfg_bit_i = 1'b0;
  logic [N-1:0]  hit_i = '0;
  logic          clear_i = 1'b0, tp_strobe_i = 1'b0, start_i = 1'b0;
  logic [N-1:0]  inject_o;
  logic [2:0]    fastor_o;
  logic          busy_o, done_o, out_valid_o;
  logic [AW-1:0] sel_addr_o;
  logic [3:0]    adc_code_i;
  logic          out_ready_i = 1'b0;
  logic [DW-1:0] out_data_o;

  int checks = 0;
  int errors = 0;

  logic [N-1:0] mask_m = '0, tpen_m = '0, hit_m = '0;

  always #10 clk = ~clk;

  spx_readout_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en_i(cfg_en_i), .cfg_bit_i(cfg_bit_i),
    .hit_i(hit_i), .clear_i(clear_i), .tp_strobe_i(tp_strobe_i),
    .inject_o(inject_o), .fastor_o(fastor_o), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .sel_addr_o(sel_addr_o),
    .adc_code_i(adc_code_i), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_data_o(out_data_o)
  );

  function automatic logic [3:0] code_of(input int a);
    return 4'(((a * 11) + 5) ^ (a >> 3));
  endfunction

  // Converter model: one register, so the code is valid one cycle after select.
  always_ff @(posedge clk) adc_code_i <= code_of(int'(sel_addr_o));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] fastor_exp();
    logic [2:0] f = '0;
    for (int p = 0; p < N; p++)
      if (hit_m[p] && !mask_m[p]) f[((p % 16) + 2 * (p / 16)) % 3] = 1'b1;
    return f;
  endfunction

  task automatic shift_cfg(input logic [N-1:0] m, input logic [N-1:0] t);
    for (int p = N - 1; p >= 0; p--) begin
      @(negedge clk); cfg_en_i = 1'b1; cfg_bit_i = m[p];
      @(negedge clk); cfg_bit_i = t[p];
    end
    @(negedge clk); cfg_en_i = 1'b0; cfg_bit_i = 1'b0;
  endtask

  task automatic pulse_hits(input logic [N-1:0] v);
    @(negedge clk); hit_i = v;
    @(negedge clk); hit_i = '0;
    hit_m |= v;
  endtask

  task automatic idle_clear();
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
    hit_m = '0;
  endtask

  task automatic start_pulse();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic strobe_check(input string req);
    @(negedge clk); tp_strobe_i = 1'b1;
    @(negedge clk); tp_strobe_i = 1'b0;
    chk(inject_o == tpen_m, req, inject_o[63:0], tpen_m[63:0]);
    chk(inject_o[N-1:64] == tpen_m[N-1:64], req, inject_o[N-1:192], tpen_m[N-1:192]);
    @(negedge clk);
    chk(inject_o == '0, req, inject_o[63:0], 0);
  endtask

  // Drains one readout; mode selects the ready pattern.
  task automatic collect(input int mode, input string tag);
    int exp_a[$];
    int idx = 0, cyc = 0, last_x = -10;
    bit done_seen = 0, stall = 0;
    logic [DW-1:0] held = '0;
    bit r;
    for (int p = 0; p < N; p++) if (hit_m[p] && !mask_m[p]) exp_a.push_back(p);
    while (!done_seen && cyc < 5000) begin
      @(negedge clk); cyc++;
      if (stall) chk(out_valid_o && out_data_o == held, "R8 stall hold", out_data_o, held);
      if (done_o) begin
        done_seen = 1;
        if (exp_a.size() > 0) chk(cyc == last_x + 1, "R9 done timing", cyc, last_x + 1);
        else chk(cyc == 1, "R9 empty done timing", cyc, 1);
        chk(!busy_o, "R9 busy low with done", busy_o, 0);
        out_ready_i = 1'b0;
      end else begin
        case (mode)
          0: r = 1'b1;
          1: r = (cyc % 3) != 0;
          default: r = (cyc % 7) == 0;
        endcase
        out_ready_i = r;
        if (out_valid_o && r) begin
          if (idx < exp_a.size())
            chk(out_data_o == {AW'(exp_a[idx]), code_of(exp_a[idx])},
                $sformatf("R6 R7 R8 word %0d %s", idx, tag), out_data_o,
                {AW'(exp_a[idx]), code_of(exp_a[idx])});
          else chk(0, "R6 extra word", out_data_o, 0);
          idx++; last_x = cyc;
        end
        stall = out_valid_o && !r;
        held  = out_data_o;
      end
    end
    chk(done_seen, {"R9 done seen ", tag}, done_seen, 1);
    chk(idx == exp_a.size(), {"R6 word count ", tag}, idx, exp_a.size());
    @(negedge clk);
    chk(!done_o, "R9 done single cycle", done_o, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!out_valid_o && !done_o && !busy_o, "R1 control outputs", {out_valid_o, done_o, busy_o}, 0);
    chk(fastor_o == 3'b000 && inject_o == '0, "R1 lines", fastor_o, 0);
    chk(sel_addr_o == '0, "R1 select", sel_addr_o, 0);
    strobe_check("R1 enables zero");
  endtask

  task automatic t_config_inject();
    logic [N-1:0] t = '0;
    t[0] = 1'b1; t[17] = 1'b1; t[255] = 1'b1; t[128] = 1'b1;
    shift_cfg('0, t);
    tpen_m = t;
    strobe_check("R2 R5 inject pattern");
  endtask

  task automatic t_fastor();
    int pix[6] = '{0, 1, 16, 89, 255, 34};
    logic [N-1:0] m = '0;
    m[34] = 1'b1;
    shift_cfg(m, tpen_m);
    mask_m = m;
    foreach (pix[i]) begin
      idle_clear();
      @(negedge clk);
      pulse_hits(N'(1) << pix[i]);
      @(negedge clk);
      chk(fastor_o == fastor_exp(), $sformatf("R4 pixel %0d", pix[i]), fastor_o, fastor_exp());
    end
    idle_clear();
    pulse_hits((N'(1) << 52) | (N'(1) << 53) | (N'(1) << 68));
    @(negedge clk);
    chk(fastor_o == 3'b111, "R4 neighbours distinct", fastor_o, 3'b111);
    idle_clear();
    @(negedge clk);
    chk(fastor_o == 3'b000, "R4 R10 idle clear", fastor_o, 0);
  endtask

  task automatic t_readout(input int mode);
    logic [N-1:0] h = '0;
    h[0] = 1'b1; h[3] = 1'b1; h[34] = 1'b1; h[100] = 1'b1; h[101] = 1'b1;
    h[200] = 1'b1; h[255] = 1'b1;
    idle_clear();
    pulse_hits(h);
    start_pulse();
    collect(mode, $sformatf("mode %0d", mode));
  endtask

  task automatic t_full();
    idle_clear();
    shift_cfg('0, tpen_m);
    mask_m = '0;
    pulse_hits('1);
    start_pulse();
    collect(0, "full array");
  endtask

  task automatic t_empty();
    idle_clear();
    start_pulse();
    collect(0, "empty");
  endtask

  task automatic t_busy_ignores();
    logic [N-1:0] h = '0;
    h[5] = 1'b1; h[77] = 1'b1; h[254] = 1'b1;
    idle_clear();
    pulse_hits(h);
    out_ready_i = 1'b0;
    start_pulse();
    chk(busy_o, "R11 busy after start", busy_o, 1);
    start_pulse();
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
    shift_cfg('1, '1);
    chk(busy_o, "R3 still busy", busy_o, 1);
    collect(1, "busy requests");
    @(negedge clk);
    chk(fastor_o == fastor_exp(), "R10 clear ignored when busy", fastor_o, fastor_exp());
    strobe_check("R3 enables kept");
    start_pulse();
    collect(0, "R3 R10 rerun");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_config_inject();
    t_fastor();
    t_readout(0);
    t_readout(1);
    t_readout(2);
    t_empty();
    t_busy_ignores();
    t_full();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule